// File: doc/BRIEF.md
# Toggle-Addressed Video Register Array

This block holds the control registers of a small video gate array that is reached through a single I/O port. An internal two-state toggle decides how each write to that port is used. In the index state the byte selects a register. In the data state the byte is stored in the register that was last selected. A status read forces the toggle back to the index state, so software can always resynchronise before it starts a sequence.

The registered state is:
- a primary mode control register;
- a palette mask;
- a border colour;
- a secondary mode control register;
- sixteen 4-bit palette entries.

From these registers the block derives a two-bit video disable vector and a blink enable. A separate page register, written on its own strobe, produces three outputs:
- the CRT display bank;
- the CPU window bank;
- the two-bit address mode, together with the two row-address substitution selects that follow from it.

The toggle has two named states. `PH_INDEX` is the reset state. `PH_DATA` is entered from `PH_INDEX` by a port write when no status read is present. `PH_DATA` returns to `PH_INDEX` on any port write or any status read. `PH_INDEX` stays where it is on a status read.

Top module: `vgaff_top`

## Requirements
- R1: After reset the toggle is in `PH_INDEX`, all control registers, palette entries and video disable bits are zero, and the page register holds CRT page 7, CPU page 7 and address mode 0.
- R2: Each port write inverts the toggle. In `PH_INDEX` the byte loads the index register. In `PH_DATA` the byte is written to the register named by the index.
- R3: A status read puts the toggle in `PH_INDEX` on the next cycle. A port write in the same cycle is still decoded by the state the toggle held before that edge.
- R4: Loading an index with bit 4 set sets video disable bit 1. Loading an index with bit 4 clear clears it.
- R5: A data write to index 0x00 stores the mode control byte. Video disable bit 0 becomes the inverse of the byte's bit 3, and the blink output follows the byte's bit 5.
- R6: Data writes to index 0x01, 0x02 and 0x03 store the full byte in the palette mask, the border colour and the secondary mode register respectively.
- R7: Data writes to index 0x10 through 0x1F store the low 4 bits of the byte in palette entry (index − 0x10). The entry can be read back through the palette select port.
- R8: Data writes to any other index change no register.
- R9: A page write splits the byte into CRT page (bits 2:0), CPU page (bits 5:3) and address mode (bits 7:6). The CPU bank output is the CPU page.
- R10: When address mode bit 1 (byte bit 7) is set, the CRT bank output is the CRT page with bit 0 forced to zero. Otherwise it is the CRT page unchanged.
- R11: The select that substitutes row-address bit 0 for CRTC address bit 12 equals address mode bit 0. The select that substitutes row-address bit 1 for page bit 0 equals address mode bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| port_we | input | 1 | Write strobe for the shared index/data port |
| port_wdata | input | 8 | Byte written to the shared port |
| stat_rd | input | 1 | Status read strobe; returns the toggle to index state |
| page_we | input | 1 | Page register write strobe |
| page_wdata | input | 8 | Page register byte |
| pal_sel | input | 4 | Palette entry to read back |
| data_phase | output | 1 | 1 when the next port write is data |
| mode_ctl | output | 8 | Primary mode control register |
| pal_mask | output | 8 | Palette mask register |
| border_col | output | 8 | Border colour register |
| mode_ctl2 | output | 8 | Secondary mode control register |
| pal_rdata | output | 4 | Palette entry chosen by pal_sel |
| video_off | output | 2 | Video disable vector; bit 0 from mode control, bit 1 from index bit 4 |
| blink_en | output | 1 | Blink enable |
| crt_bank | output | 3 | Displayed memory bank |
| cpu_bank | output | 3 | Bank mapped into the processor window |
| addr_mode | output | 2 | Video address mode |
| row_a12_sel | output | 1 | Row-address bit 0 replaces CRTC address bit 12 |
| row_pg0_sel | output | 1 | Row-address bit 1 replaces page bit 0 |

## Verification
If the toggle slips by one write, every later index/data pair lands in the wrong place. The next register check then shows an index byte stored as data, and `data_phase` shows the inverted value one cycle after the faulty edge. A wrong index shows up as video disable bit 1 on the cycle after the index write, or as a data byte that appears in a neighbouring register or palette entry. Page decoding errors appear on the bank outputs one cycle after the page write, most directly as an odd CRT bank in the 32 KiB modes.

// File: rtl/vgaff_pkg.sv
package vgaff_pkg;
    typedef enum logic {
        PH_INDEX = 1'b0,
        PH_DATA  = 1'b1
    } phase_e;

    localparam int unsigned DW = 8;
    localparam logic [DW-1:0] IDX_MODE   = 8'h00;
    localparam logic [DW-1:0] IDX_MASK   = 8'h01;
    localparam logic [DW-1:0] IDX_BORDER = 8'h02;
    localparam logic [DW-1:0] IDX_MODE2  = 8'h03;
    localparam logic [DW-1:0] IDX_PAL    = 8'h10;
endpackage

// File: rtl/vgaff_phase.sv
module vgaff_phase
    import vgaff_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic port_we,
    input  logic stat_rd,
    output phase_e phase,
    output logic idx_we,
    output logic dat_we
);
    phase_e phase_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) phase <= PH_INDEX;
        else        phase <= phase_nx;
    end

    always_comb begin
        phase_nx = phase;
        unique case (phase)
            PH_INDEX: if (!stat_rd && port_we) phase_nx = PH_DATA;
            PH_DATA:  if (stat_rd || port_we)  phase_nx = PH_INDEX;
        endcase
    end

    always_comb begin
        idx_we = 1'b0;
        dat_we = 1'b0;
        unique case (phase)
            PH_INDEX: idx_we = port_we;
            PH_DATA:  dat_we = port_we;
        endcase
    end

    p_toggle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (port_we && !stat_rd) |=> (phase != $past(phase)));

    p_resync_r3: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd |=> (phase == PH_INDEX));
endmodule

// File: rtl/vgaff_regs.sv
module vgaff_regs
    import vgaff_pkg::*;
#(
    parameter int unsigned PAL_N = 16,
    parameter int unsigned PAL_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            idx_we,
    input  logic            dat_we,
    input  logic [DW-1:0]   wdata,
    input  logic [$clog2(PAL_N)-1:0] pal_sel,
    output logic [DW-1:0]   mode_ctl,
    output logic [DW-1:0]   pal_mask,
    output logic [DW-1:0]   border_col,
    output logic [DW-1:0]   mode_ctl2,
    output logic [PAL_W-1:0] pal_rdata,
    output logic [1:0]      video_off,
    output logic            blink_en
);
    localparam int unsigned PAL_AW = $clog2(PAL_N);

    logic [DW-1:0] index_q;
    logic [PAL_W-1:0] pal_q [PAL_N];
    logic pal_hit;

    assign pal_hit = (index_q[DW-1:PAL_AW] == IDX_PAL[DW-1:PAL_AW]);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            index_q      <= '0;
            video_off[1] <= 1'b0;
        end else if (idx_we) begin
            index_q      <= wdata;
            video_off[1] <= wdata[4];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_ctl     <= '0;
            pal_mask     <= '0;
            border_col   <= '0;
            mode_ctl2    <= '0;
            video_off[0] <= 1'b0;
        end else if (dat_we) begin
            unique case (index_q)
                IDX_MODE: begin
                    mode_ctl     <= wdata;
                    video_off[0] <= ~wdata[3];
                end
                IDX_MASK:   pal_mask   <= wdata;
                IDX_BORDER: border_col <= wdata;
                IDX_MODE2:  mode_ctl2  <= wdata;
                default: ;
            endcase
        end
    end

    generate
        for (genvar g = 0; g < PAL_N; g++) begin : g_pal
            always_ff @(posedge clk) begin
                if (!rst_n)
                    pal_q[g] <= '0;
                else if (dat_we && pal_hit && index_q[PAL_AW-1:0] == PAL_AW'(g))
                    pal_q[g] <= wdata[PAL_W-1:0];
            end
        end
    endgenerate

    assign pal_rdata = pal_q[pal_sel];
    assign blink_en  = mode_ctl[5];

    p_blank_idx_r4: assert property (@(posedge clk) disable iff (!rst_n)
        idx_we |=> (video_off[1] == $past(wdata[4])));

    p_mode_blank_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_we && index_q == IDX_MODE) |=> (video_off[0] == !mode_ctl[3]));

    p_blank_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !idx_we |=> $stable(video_off[1]));
endmodule

// File: rtl/vgaff_page.sv
module vgaff_page #(
    parameter int unsigned PG_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               page_we,
    input  logic [2*PG_W+1:0]  page_wdata,
    output logic [PG_W-1:0]    crt_bank,
    output logic [PG_W-1:0]    cpu_bank,
    output logic [1:0]         addr_mode,
    output logic               row_a12_sel,
    output logic               row_pg0_sel
);
    localparam logic [PG_W-1:0] PG_ALL  = '1;
    localparam logic [PG_W-1:0] PG_EVEN = PG_ALL & ~PG_W'(1);

    logic [PG_W-1:0] crt_mask;
    assign crt_mask = page_wdata[2*PG_W+1] ? PG_EVEN : PG_ALL;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crt_bank  <= PG_ALL;
            cpu_bank  <= PG_ALL;
            addr_mode <= 2'b00;
        end else if (page_we) begin
            crt_bank  <= page_wdata[PG_W-1:0] & crt_mask;
            cpu_bank  <= page_wdata[2*PG_W-1:PG_W];
            addr_mode <= page_wdata[2*PG_W+1:2*PG_W];
        end
    end

    assign row_a12_sel = addr_mode[0];
    assign row_pg0_sel = addr_mode[1];

    p_even_bank_r10: assert property (@(posedge clk) disable iff (!rst_n)
        addr_mode[1] |-> (crt_bank[0] == 1'b0));

    p_page_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !page_we |=> ($stable(cpu_bank) && $stable(crt_bank) && $stable(addr_mode)));
endmodule

// File: rtl/vgaff_top.sv
module vgaff_top
    import vgaff_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       port_we,
    input  logic [7:0] port_wdata,
    input  logic       stat_rd,
    input  logic       page_we,
    input  logic [7:0] page_wdata,
    input  logic [3:0] pal_sel,
    output logic       data_phase,
    output logic [7:0] mode_ctl,
    output logic [7:0] pal_mask,
    output logic [7:0] border_col,
    output logic [7:0] mode_ctl2,
    output logic [3:0] pal_rdata,
    output logic [1:0] video_off,
    output logic       blink_en,
    output logic [2:0] crt_bank,
    output logic [2:0] cpu_bank,
    output logic [1:0] addr_mode,
    output logic       row_a12_sel,
    output logic       row_pg0_sel
);
    phase_e phase;
    logic idx_we, dat_we;

    vgaff_phase u_phase (
        .clk(clk), .rst_n(rst_n), .port_we(port_we), .stat_rd(stat_rd),
        .phase(phase), .idx_we(idx_we), .dat_we(dat_we)
    );

    vgaff_regs #(.PAL_N(16), .PAL_W(4)) u_regs (
        .clk(clk), .rst_n(rst_n), .idx_we(idx_we), .dat_we(dat_we),
        .wdata(port_wdata), .pal_sel(pal_sel),
        .mode_ctl(mode_ctl), .pal_mask(pal_mask), .border_col(border_col),
        .mode_ctl2(mode_ctl2), .pal_rdata(pal_rdata),
        .video_off(video_off), .blink_en(blink_en)
    );

    vgaff_page #(.PG_W(3)) u_page (
        .clk(clk), .rst_n(rst_n), .page_we(page_we), .page_wdata(page_wdata),
        .crt_bank(crt_bank), .cpu_bank(cpu_bank), .addr_mode(addr_mode),
        .row_a12_sel(row_a12_sel), .row_pg0_sel(row_pg0_sel)
    );

    assign data_phase = (phase == PH_DATA);
endmodule

// File: tb/tb_vgaff_top.sv
module tb_vgaff_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic port_we = 1'b0, stat_rd = 1'b0, page_we = 1'b0;
    logic [7:0] port_wdata = '0, page_wdata = '0;
    logic [3:0] pal_sel = '0;
    logic data_phase, blink_en, row_a12_sel, row_pg0_sel;
    logic [7:0] mode_ctl, pal_mask, border_col, mode_ctl2;
    logic [3:0] pal_rdata;
    logic [1:0] video_off, addr_mode;
    logic [2:0] crt_bank, cpu_bank;

    int n_chk = 0, n_bad = 0;

    always #2.5 clk = ~clk;

    vgaff_top dut (.*);

    // op: 0 port write, 1 page write, 2 status read, 3 idle
    // sel: 0 mode,1 mask,2 border,3 mode2,4 video_off,5 blink,6 crt,7 cpu,
    //      8 addr_mode,9 phase,10 palette,11 {a12_sel,pg0_sel}
    // fields: op[29:28] data[27:20] sel[19:16] psel[15:12] exp[11:4] req[3:0]
    localparam int NV = 30;
    localparam logic [29:0] VEC [NV] = '{
        {2'd0, 8'h00, 4'd9,  4'd0, 8'h01, 4'd2},  // R2 index loaded, toggle set
        {2'd0, 8'h28, 4'd0,  4'd0, 8'h28, 4'd2},  // R2 data into mode
        {2'd3, 8'h00, 4'd4,  4'd0, 8'h00, 4'd5},  // R5 bit3 set -> enabled
        {2'd3, 8'h00, 4'd5,  4'd0, 8'h01, 4'd5},  // R5 blink
        {2'd0, 8'h01, 4'd9,  4'd0, 8'h01, 4'd2},  // R2
        {2'd0, 8'hA5, 4'd1,  4'd0, 8'hA5, 4'd6},  // R6 mask
        {2'd0, 8'h02, 4'd9,  4'd0, 8'h01, 4'd2},  // R2
        {2'd0, 8'h3C, 4'd2,  4'd0, 8'h3C, 4'd6},  // R6 border
        {2'd0, 8'h03, 4'd9,  4'd0, 8'h01, 4'd2},  // R2
        {2'd0, 8'h18, 4'd3,  4'd0, 8'h18, 4'd6},  // R6 mode2
        {2'd0, 8'h00, 4'd4,  4'd0, 8'h00, 4'd4},  // R4 bit4 clear
        {2'd0, 8'h20, 4'd4,  4'd0, 8'h01, 4'd5},  // R5 bit3 clear -> off
        {2'd3, 8'h00, 4'd5,  4'd0, 8'h01, 4'd5},  // R5 blink still set
        {2'd0, 8'h1A, 4'd4,  4'd0, 8'h03, 4'd4},  // R4 bit4 set
        {2'd0, 8'hF7, 4'd10, 4'd10, 8'h07, 4'd7}, // R7 low nibble only
        {2'd0, 8'h05, 4'd4,  4'd0, 8'h01, 4'd4},  // R4 cleared again
        {2'd0, 8'h99, 4'd1,  4'd0, 8'hA5, 4'd8},  // R8 unused index
        {2'd3, 8'h00, 4'd2,  4'd0, 8'h3C, 4'd8},  // R8 border untouched
        {2'd0, 8'h10, 4'd9,  4'd0, 8'h01, 4'd2},  // R2
        {2'd0, 8'hFF, 4'd10, 4'd0, 8'h0F, 4'd7},  // R7 entry 0
        {2'd3, 8'h00, 4'd10, 4'd10, 8'h07, 4'd7}, // R7 entry A intact
        {2'd0, 8'h00, 4'd9,  4'd0, 8'h01, 4'd2},  // R2
        {2'd2, 8'h00, 4'd9,  4'd0, 8'h00, 4'd3},  // R3 status read resync
        {2'd0, 8'h01, 4'd9,  4'd0, 8'h01, 4'd3},  // R3 next write is index
        {2'd0, 8'h11, 4'd1,  4'd0, 8'h11, 4'd3},  // R3 data to index 1
        {2'd1, 8'hF5, 4'd6,  4'd0, 8'h04, 4'd10}, // R10 even bank
        {2'd3, 8'h00, 4'd7,  4'd0, 8'h06, 4'd9},  // R9 cpu page
        {2'd3, 8'h00, 4'd11, 4'd0, 8'h03, 4'd11}, // R11 both selects
        {2'd1, 8'h4F, 4'd6,  4'd0, 8'h07, 4'd10}, // R10 mode 1 keeps bit0
        {2'd3, 8'h00, 4'd11, 4'd0, 8'h02, 4'd11}  // R11 a12 only
    };

    function automatic logic [7:0] observe(input logic [3:0] sel);
        case (sel)
            4'd0:  return mode_ctl;
            4'd1:  return pal_mask;
            4'd2:  return border_col;
            4'd3:  return mode_ctl2;
            4'd4:  return {6'd0, video_off};
            4'd5:  return {7'd0, blink_en};
            4'd6:  return {5'd0, crt_bank};
            4'd7:  return {5'd0, cpu_bank};
            4'd8:  return {6'd0, addr_mode};
            4'd9:  return {7'd0, data_phase};
            4'd10: return {4'd0, pal_rdata};
            default: return {6'd0, row_a12_sel, row_pg0_sel};
        endcase
    endfunction

    task automatic check(input logic [3:0] sel, input logic [7:0] exp, input int req);
        logic [7:0] act;
        act = observe(sel);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL R%0d sel=%0d actual=%h expected=%h", req, sel, act, exp);
        end
    endtask

    task automatic step(input logic [1:0] op, input logic [7:0] d, input logic sr);
        @(negedge clk);
        port_we = (op == 2'd0);
        page_we = (op == 2'd1);
        stat_rd = (op == 2'd2) || sr;
        port_wdata = d;
        page_wdata = d;
        @(posedge clk);
        @(negedge clk);
        port_we = 1'b0; page_we = 1'b0; stat_rd = 1'b0;
    endtask

    initial begin
        #200000;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R1 reset state
        check(4'd9, 8'h00, 1);
        check(4'd6, 8'h07, 1);
        check(4'd7, 8'h07, 1);
        check(4'd8, 8'h00, 1);
        check(4'd4, 8'h00, 1);
        check(4'd0, 8'h00, 1);
        check(4'd10, 8'h00, 1);

        for (int i = 0; i < NV; i++) begin
            pal_sel = VEC[i][15:12];
            step(VEC[i][29:28], VEC[i][27:20], 1'b0);
            check(VEC[i][19:16], VEC[i][11:4], int'(VEC[i][3:0]));
        end

        // R3 write together with status read while in data phase
        step(2'd0, 8'h02, 1'b0);
        step(2'd0, 8'h44, 1'b1);
        check(4'd2, 8'h44, 3);
        check(4'd9, 8'h00, 3);
        step(2'd0, 8'h03, 1'b0);
        check(4'd9, 8'h01, 3);
        check(4'd2, 8'h44, 3);

        // R10 address mode 2: odd page forced even
        step(2'd1, 8'h9B, 1'b0);
        check(4'd6, 8'h02, 10);
        check(4'd7, 8'h03, 9);
        check(4'd8, 8'h02, 9);

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule